// File: doc/BRIEF.md
# Preloadable Interval Timer

This block is a 16-bit interval timer that sits behind an 8-bit register bus. A free-standing tick strobe, produced elsewhere from the system clock, advances an up-counter. When the counter steps past its top value 0xFFFF, it reloads from a software-programmed preload value on that same tick and latches a pending interrupt. The time between interrupts is therefore (65536 − preload) ticks. With a 160 000 per second tick, a rate of f interrupts per second needs a preload of 65536 − 160000/f. For example, 100 Hz needs 63936 (0xF9C0).

Software sees six byte registers. The preload sits at byte addresses 0 and 1, with the high byte at the even address. The live count sits at 2 and 3 in the same byte order. A mode register at 4 selects clear, freeze or run. An interrupt register at 5 holds the pending flag, an enable bit and a 3-bit priority level. The request line is raised only when an enabled interrupt with a non-zero level is pending, and the level field is driven out beside it for an external priority encoder. Address decoding above these six bytes, vector generation and arbitration between timers belong to the surrounding logic.

Top module: `ivl_timer_top`

## Requirements
- R1: After reset, every register reads 0, the mode is clear, the pending flag is 0, and `irq` and `irq_level` are 0.
- R2: In run mode (mode bits 1:0 = 3), each clock with `tick` high adds one to the count. A clock with `tick` low leaves the count unchanged.
- R3: Mode code 0 forces the count to 0 and holds it there, regardless of ticks and of bus writes to the count bytes.
- R4: Mode codes 1 and 2 freeze the count at its present value while ticks arrive. The mode register reads back the code written.
- R5: A tick in run mode while the count is 0xFFFF loads the preload value into the count on that tick and sets the pending flag. The pending flag is read as bit 7 of address 5.
- R6: Writing address 5 with bit 7 = 1 clears the pending flag. Writing bit 7 = 0 leaves it unchanged. If a wrap occurs in the same cycle as the clearing write, the flag stays set.
- R7: `irq` is 1 exactly when the pending flag, the enable bit (bit 3 of address 5) and a non-zero level (bits 2:0 of address 5) are all present. `irq_level` always shows the level bits.
- R8: Writing the preload while running does not disturb the count. The new value is used at the next wrap.
- R9: The register map is as follows. Address 0 is the preload high byte and address 1 the preload low byte. Address 2 is the count high byte and address 3 the count low byte. Address 4 holds the mode in bits 1:0, and address 5 is the interrupt register. Addresses 6 and 7 read 0 and ignore writes. A byte write to the count replaces that byte and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count strobe, one clock wide per count step |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte, combinational |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level of the request |

## Verification
The assertions assume that a bus write lands on exactly one byte per clock. They also assume that a write to a count byte is the only event other than a tick or the mode that may change the count, so the step, freeze and wrap properties are disabled in cycles that carry a count write. They take `tick` as a one-clock strobe sampled at each edge and make no assumption about its spacing. The bench keeps to this by setting the mode and count only while the timer is frozen, and by creating a tick and a write in the same clock only in the two directed cases that test those collisions.

// File: rtl/ivl_timer_pkg.sv
// Shared constants and types for the preloadable interval timer.
// Assumes an 8-bit bus and a counter that is a whole number of bytes wide.
package ivl_timer_pkg;
    localparam int DATA_W    = 8;
    localparam int CNT_W     = 16;
    localparam int ADDR_W    = 3;
    localparam int LVL_W     = 3;
    localparam int CNT_BYTES = CNT_W / DATA_W;

    localparam logic [ADDR_W-1:0] A_PRE_HI = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(CNT_BYTES);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(2 * CNT_BYTES);
    localparam logic [ADDR_W-1:0] A_INTC   = ADDR_W'(2 * CNT_BYTES + 1);

    localparam int INTC_PEND_BIT = 7;
    localparam int INTC_EN_BIT   = 3;

    typedef enum logic [1:0] {
        MODE_CLEAR    = 2'd0,
        MODE_HOLD     = 2'd1,
        MODE_HOLD_ALT = 2'd2,
        MODE_RUN      = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/ivl_timer_regs.sv
// Register file of the timer: preload, mode, enable and level storage,
// write strobes for the count bytes and the acknowledge, and the read mux.
// Assumes one byte access per clock; high byte at the lower address.
module ivl_timer_regs
    import ivl_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [CNT_W-1:0]     count,
    input  logic                 pending,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [CNT_W-1:0]     preload,
    output tmr_mode_e            mode,
    output logic                 irq_en,
    output logic [LVL_W-1:0]     level,
    output logic [CNT_BYTES-1:0] cnt_we,
    output logic                 ack
);
    // Preload byte lanes and count byte strobes, one per byte of the counter.
    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_byte
        localparam int LSB = (CNT_BYTES - 1 - b) * DATA_W;
        logic pre_we;
        assign pre_we    = bus_wr && (bus_addr == A_PRE_HI + ADDR_W'(b));
        assign cnt_we[b] = bus_wr && (bus_addr == A_CNT_HI + ADDR_W'(b));

        // Purpose: hold one byte of the preload value.
        always_ff @(posedge clk) begin
            if (!rst_n)      preload[LSB +: DATA_W] <= '0;
            else if (pre_we) preload[LSB +: DATA_W] <= bus_wdata;
        end
    end

    // Purpose: hold the mode code and the interrupt enable and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MODE_CLEAR;
            irq_en <= 1'b0;
            level  <= '0;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            mode <= tmr_mode_e'(bus_wdata[1:0]);
        end else if (bus_wr && bus_addr == A_INTC) begin
            irq_en <= bus_wdata[INTC_EN_BIT];
            level  <= bus_wdata[LVL_W-1:0];
        end
    end

    assign ack = bus_wr && (bus_addr == A_INTC) && bus_wdata[INTC_PEND_BIT];

    // Purpose: select the addressed byte for reading; unmapped bytes read 0.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (bus_addr == A_PRE_HI + ADDR_W'(b))
                bus_rdata = preload[(CNT_BYTES - 1 - b) * DATA_W +: DATA_W];
            if (bus_addr == A_CNT_HI + ADDR_W'(b))
                bus_rdata = count[(CNT_BYTES - 1 - b) * DATA_W +: DATA_W];
        end
        if (bus_addr == A_CTRL) begin
            bus_rdata[1:0] = mode;
        end
        if (bus_addr == A_INTC) begin
            bus_rdata[INTC_PEND_BIT] = pending;
            bus_rdata[INTC_EN_BIT]   = irq_en;
            bus_rdata[LVL_W-1:0]     = level;
        end
    end
endmodule

// File: rtl/ivl_timer_counter.sv
// Up-counter core: clears, freezes or steps on tick, and reloads from the
// preload on the tick that would pass the all-ones value.
// Assumes the mode decode is stable for the clock it is sampled in.
module ivl_timer_counter
    import ivl_timer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  tmr_mode_e            mode,
    input  logic                 tick,
    input  logic [CNT_W-1:0]     preload,
    input  logic [CNT_BYTES-1:0] cnt_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [CNT_W-1:0]     count,
    output logic                 wrap
);
    logic [CNT_W-1:0] wr_val;
    logic             step;

    // Purpose: merge written bytes into the current count.
    always_comb begin
        wr_val = count;
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (cnt_we[b]) wr_val[(CNT_BYTES - 1 - b) * DATA_W +: DATA_W] = bus_wdata;
        end
    end

    assign step = (mode == MODE_RUN) && tick && !(|cnt_we);
    assign wrap = step && (count == '1);

    // Purpose: update the count by priority clear, bus write, reload, step.
    always_ff @(posedge clk) begin
        if (!rst_n)                 count <= '0;
        else if (mode == MODE_CLEAR) count <= '0;
        else if (|cnt_we)           count <= wr_val;
        else if (wrap)              count <= preload;
        else if (step)              count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/ivl_timer_irq.sv
// Interrupt stage: latches a pending flag on wrap, clears it on a
// write-one acknowledge, and gates the request with enable and level.
// Assumes a wrap and an acknowledge in one clock must not lose the event.
module ivl_timer_irq
    import ivl_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             ack,
    input  logic             irq_en,
    input  logic [LVL_W-1:0] level,
    output logic             pending,
    output logic             irq,
    output logic [LVL_W-1:0] irq_level
);
    // Purpose: pending flag; a new wrap wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (wrap) pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end

    assign irq       = pending && irq_en && (|level);
    assign irq_level = level;
endmodule

// File: rtl/ivl_timer_top.sv
// Top of the preloadable interval timer: wires the register file, the
// counter core and the interrupt stage. Assumes tick is a one-clock strobe.
module ivl_timer_top
    import ivl_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [LVL_W-1:0]  irq_level
);
    logic [CNT_W-1:0]     count_q;
    logic [CNT_W-1:0]     preload_q;
    tmr_mode_e            mode_q;
    logic                 irq_en_q;
    logic [LVL_W-1:0]     level_q;
    logic [CNT_BYTES-1:0] cnt_we;
    logic                 ack;
    logic                 wrap;
    logic                 pending_q;

    ivl_timer_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .count(count_q), .pending(pending_q),
        .bus_rdata(bus_rdata), .preload(preload_q), .mode(mode_q),
        .irq_en(irq_en_q), .level(level_q), .cnt_we(cnt_we), .ack(ack)
    );

    ivl_timer_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .tick(tick),
        .preload(preload_q), .cnt_we(cnt_we), .bus_wdata(bus_wdata),
        .count(count_q), .wrap(wrap)
    );

    ivl_timer_irq u_irq (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack), .irq_en(irq_en_q),
        .level(level_q), .pending(pending_q), .irq(irq), .irq_level(irq_level)
    );
endmodule

// File: rtl/ivl_timer_chk.sv
// Property checker for the interval timer, bound into the top module.
// Assumes one bus byte access per clock.
module ivl_timer_chk
    import ivl_timer_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              ack_bit,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  preload,
    input logic              pending,
    input logic              irq_en,
    input logic [LVL_W-1:0]  level,
    input logic              irq
);
    logic cnt_hit, run_tick, ack_wr;
    assign cnt_hit  = bus_wr && (bus_addr == A_CNT_HI || bus_addr == A_CNT_HI + ADDR_W'(1));
    assign run_tick = (mode == 2'd3) && tick && !cnt_hit;
    assign ack_wr   = bus_wr && (bus_addr == A_INTC) && ack_bit;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> (count == '0)); // R3
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1 || mode == 2'd2) && !cnt_hit) |=> $stable(count)); // R4
    AST_RUN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && count != '1) |=> (count == CNT_W'($past(count) + CNT_W'(1)))); // R2
    AST_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd3) && !tick && !cnt_hit) |=> $stable(count)); // R2
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && count == '1) |=> (count == $past(preload) && pending)); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !(run_tick && count == '1)) |=> !pending); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pending && irq_en && level != '0)); // R7
endmodule

bind ivl_timer_top ivl_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .ack_bit(bus_wdata[7]), .mode(mode_q), .count(count_q), .preload(preload_q),
    .pending(pending_q), .irq_en(irq_en_q), .level(level_q), .irq(irq)
);

// File: tb/ivl_timer_tb_top.sv
module ivl_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic [2:0] irq_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ivl_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .irq_level(irq_level)
    );

    // {preload, start count, ticks, expected count, expected pending}
    localparam int NV = 6;
    localparam logic [56:0] VEC [NV] = '{
        {16'hF9C0, 16'hFFFE, 8'd1,  16'hFFFF, 1'b0},
        {16'hF9C0, 16'hFFFE, 8'd2,  16'hF9C0, 1'b1},
        {16'h1234, 16'hFFFF, 8'd1,  16'h1234, 1'b1},
        {16'hFFFF, 16'hFFFF, 8'd3,  16'hFFFF, 1'b1},
        {16'h0000, 16'h0010, 8'd16, 16'h0020, 1'b0},
        {16'hFFFE, 16'hFFFD, 8'd5,  16'hFFFE, 1'b1}
    };

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [15:0] c);
        logic [7:0] h, l;
        rd(3'd2, h);
        rd(3'd3, l);
        c = {h, l};
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic set_cnt(logic [15:0] c);
        wr(3'd2, c[15:8]);
        wr(3'd3, c[7:0]);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset register", d, 0);
        end
        chk("R1 irq after reset", irq, 0);
        chk("R1 irq_level after reset", irq_level, 0);

        // R9: unmapped addresses ignore writes and read 0
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hA5);
        rd(3'd6, d); chk("R9 unmapped 6", d, 0);
        rd(3'd7, d); chk("R9 unmapped 7", d, 0);
        rd(3'd4, d); chk("R9 mode untouched", d, 0);
        rd(3'd0, d); chk("R9 preload untouched", d, 0);

        // Table walk: R2, R5 (including the 100 Hz preload 0xF9C0)
        for (int i = 0; i < NV; i++) begin
            wr(3'd4, 8'h01);
            wr(3'd5, 8'h80);
            wr(3'd0, VEC[i][56:49]);
            wr(3'd1, VEC[i][48:41]);
            set_cnt(VEC[i][40:25]);
            wr(3'd4, 8'h03);
            ticks(int'(VEC[i][24:17]));
            wr(3'd4, 8'h01);
            rd_cnt(c);
            chk("R2/R5 table count", c, int'(VEC[i][16:1]));
            rd(3'd5, d);
            chk("R5 table pending", d[7], VEC[i][0]);
        end

        // R3: clear mode zeroes and holds the count, ignores count writes
        wr(3'd5, 8'h80);
        set_cnt(16'h1234);
        wr(3'd4, 8'h00);
        rd_cnt(c); chk("R3 cleared", c, 0);
        ticks(3);
        set_cnt(16'h5678);
        rd_cnt(c); chk("R3 held at zero", c, 0);

        // R4: freeze codes 1 and 2
        wr(3'd4, 8'h01);
        set_cnt(16'h0100);
        ticks(4);
        rd_cnt(c); chk("R4 freeze code 1", c, 16'h0100);
        wr(3'd4, 8'h02);
        ticks(4);
        rd_cnt(c); chk("R4 freeze code 2", c, 16'h0100);
        rd(3'd4, d); chk("R4 mode readback", d, 2);

        // R2: running without ticks leaves the count alone
        wr(3'd4, 8'h03);
        repeat (6) @(negedge clk);
        rd_cnt(c); chk("R2 no tick", c, 16'h0100);
        ticks(2);
        rd_cnt(c); chk("R2 two ticks", c, 16'h0102);

        // R9: count byte write beats a tick in the same clock
        @(negedge clk);
        tick = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h77; bus_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd_cnt(c); chk("R9 write beats tick", c, 16'h0177);

        // R7: request gating
        wr(3'd4, 8'h01);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        set_cnt(16'hFFFF);
        wr(3'd5, 8'h0D);
        wr(3'd4, 8'h03);
        ticks(1);
        wr(3'd4, 8'h01);
        #1;
        chk("R7 irq raised", irq, 1);
        chk("R7 irq_level", irq_level, 5);
        rd(3'd5, d); chk("R7 intc readback", d, 8'h8D);
        wr(3'd5, 8'h08);
        #1 chk("R7 level 0 suppresses", irq, 0);
        rd(3'd5, d); chk("R6 write 0 keeps pending", d, 8'h88);
        wr(3'd5, 8'h05);
        #1 chk("R7 enable 0 suppresses", irq, 0);
        wr(3'd5, 8'h0D);
        #1 chk("R7 irq back", irq, 1);

        // R6: acknowledge clears; a wrap in the same clock wins
        wr(3'd5, 8'h8D);
        #1 chk("R6 ack drops irq", irq, 0);
        rd(3'd5, d); chk("R6 ack clears pending", d, 8'h0D);
        set_cnt(16'hFFFF);
        wr(3'd4, 8'h03);
        @(negedge clk);
        tick = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h8D; bus_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rd(3'd5, d); chk("R6 wrap beats ack", d[7], 1);

        // R8: preload change while running applies at next wrap
        wr(3'd4, 8'h01);
        wr(3'd5, 8'h80);
        wr(3'd0, 8'h10); wr(3'd1, 8'h00);
        set_cnt(16'hFFFD);
        wr(3'd4, 8'h03);
        ticks(1);
        wr(3'd0, 8'h20);
        rd_cnt(c); chk("R8 count undisturbed", c, 16'hFFFE);
        ticks(2);
        rd_cnt(c); chk("R8 new preload used", c, 16'h2000);

        done = 1'b1;
        finish_run();
    end
endmodule